// File: doc/BRIEF.md
# Output-Stationary Systolic MAC Tile

This block computes one small integer matrix product with accumulation, D = A×B + C, over a 4×4 grid of multiply-accumulate cells. A single start pulse captures a whole 4×4 tile of A and a whole 4×4 tile of B. The block then runs with no further control until the tile is finished. Rows of A are fed in from the left edge and columns of B from the top edge. Each row and each column is delayed by its index so that operands with the same inner index k arrive at cell (i,j) in the same step. Every cell multiplies the two operands it receives and adds the product into its own accumulator. It also hands the A operand to its right neighbour and the B operand to the cell below, so one value is reused across a whole row or column. Once an edge has delivered its K operands, it feeds zeros.

The accumulators are wider than the operands and stay in place, which makes the grid output-stationary. Before a run, software-side logic loads C into the accumulators one row at a time through the preload port. After completion, D leaves row by row through a 4-wide result port. If no preload is done between runs, the accumulators keep their contents, so several runs chain into one longer inner product.

Top module: `systolic_mac_tile`

## Requirements
- R1: After reset, busy, done and outValid are low.
- R2: Operands are signed 8-bit and accumulators signed 32-bit. Each result element equals C[i][j] plus the sum over k of A[i][k]·B[k][j], with products sign-extended. A[i][k] sits at aTile bits (i·4+k)·8 upward, and B[k][j] at bTile bits (k·4+j)·8 upward.
- R3: A start sampled while busy is low is accepted. busy is high from the cycle after that edge. done is high for exactly one cycle, in the cycle after the 10th clock edge (K+M+N−2) following the accepting edge.
- R4: start has no effect while busy is high: the running tile's timing and results are unchanged.
- R5: outValid is high for 4 consecutive cycles, beginning in the cycle where done is high. During those cycles outRow counts 0,1,2,3 and outData carries that row's results, with element j at bits j·32 upward.
- R6: A preloadEn sampled while busy is low writes preloadData, with element j at bits j·32 upward, into accumulator row preloadRow. A preloadEn sampled while busy is high is ignored.
- R7: Without a preload between runs, a new run adds its products onto the previous results.
- R8: busy falls in the cycle after the last readout row, and outValid falls with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a tile; captures aTile and bTile |
| aTile | input | 128 | Sixteen signed 8-bit A elements, row-major |
| bTile | input | 128 | Sixteen signed 8-bit B elements, row-major |
| preloadEn | input | 1 | Write one accumulator row |
| preloadRow | input | 2 | Accumulator row to write |
| preloadData | input | 128 | Four signed 32-bit accumulator values |
| busy | output | 1 | Tile running or being read out |
| done | output | 1 | One-cycle completion pulse |
| outValid | output | 1 | outData holds a valid result row |
| outRow | output | 2 | Index of the row on outData |
| outData | output | 128 | Four signed 32-bit results |

## Verification
An identity A with a random B checks that the skew brings each B element to the correct cell. If that alignment is off, the returned rows appear shifted or mixed with neighbouring terms. Tiles filled entirely with −128, and tiles mixing −128 with 127, drive the products to their extremes and expose any sign-extension fault in the accumulator. Two runs chained without a preload separate true accumulation from clearing on start. A stray start and a stray preload injected in the middle of a run must leave the done timing and the results untouched. A sweep of random tiles with random negative and positive preloads then covers the general arithmetic.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int TILE_M = 4;
  localparam int TILE_N = 4;
  localparam int TILE_K = 4;
  localparam int OPW    = 8;
  localparam int ACCW   = 32;
  localparam int STEPS  = TILE_K + TILE_M + TILE_N - 2;
  localparam int STEPW  = $clog2(STEPS + 1);
  localparam int ROWW   = $clog2(TILE_M);

  // strobes from the sequencer into the grid
  typedef struct packed {
    logic             capture;  // latch operand tiles, flush operand hops
    logic             run;      // one wavefront step this cycle
    logic             loadOk;   // accumulator preload permitted
    logic [STEPW-1:0] step;     // current wavefront index
    logic [ROWW-1:0]  rowSel;   // row driven onto the result port
  } ctlStrobes_t;
endpackage

// File: rtl/sa_pe.sv
module sa_pe #(
  parameter int OPW  = 8,
  parameter int ACCW = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   load,
  input  logic signed [ACCW-1:0] loadVal,
  input  logic                   run,
  input  logic signed [OPW-1:0]  aIn,
  input  logic signed [OPW-1:0]  bIn,
  output logic signed [ACCW-1:0] acc
);
  localparam int PW = 2 * OPW;

  logic signed [PW-1:0] prod;
  assign prod = aIn * bIn;

  always_ff @(posedge clk) begin
    if (!rstN)      acc <= '0;
    else if (load)  acc <= loadVal;
    else if (run)   acc <= acc + {{(ACCW-PW){prod[PW-1]}}, prod};
  end
endmodule

// File: rtl/sa_datapath.sv
module sa_datapath
  import sa_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobes_t                  ctl,
  input  logic [TILE_M*TILE_K*OPW-1:0] aTile,
  input  logic [TILE_K*TILE_N*OPW-1:0] bTile,
  input  logic                         preloadEn,
  input  logic [ROWW-1:0]              preloadRow,
  input  logic [TILE_N*ACCW-1:0]       preloadData,
  output logic [TILE_N*ACCW-1:0]       outData
);
  logic signed [OPW-1:0]  aLat  [TILE_M][TILE_K];
  logic signed [OPW-1:0]  bLat  [TILE_K][TILE_N];
  logic signed [OPW-1:0]  feedA [TILE_M];
  logic signed [OPW-1:0]  feedB [TILE_N];
  logic signed [OPW-1:0]  aSeen [TILE_M][TILE_N];
  logic signed [OPW-1:0]  bSeen [TILE_M][TILE_N];
  logic signed [OPW-1:0]  aHop  [TILE_M][TILE_N-1];
  logic signed [OPW-1:0]  bHop  [TILE_M-1][TILE_N];
  logic signed [ACCW-1:0] accAll [TILE_M][TILE_N];

  // operand capture at start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < TILE_M; i++)
        for (int k = 0; k < TILE_K; k++) aLat[i][k] <= '0;
      for (int k = 0; k < TILE_K; k++)
        for (int j = 0; j < TILE_N; j++) bLat[k][j] <= '0;
    end else if (ctl.capture) begin
      for (int i = 0; i < TILE_M; i++)
        for (int k = 0; k < TILE_K; k++) aLat[i][k] <= aTile[(i*TILE_K+k)*OPW +: OPW];
      for (int k = 0; k < TILE_K; k++)
        for (int j = 0; j < TILE_N; j++) bLat[k][j] <= bTile[(k*TILE_N+j)*OPW +: OPW];
    end
  end

  // skewed edge feed: row i / column j lag by their index, zeros outside the window
  always_comb begin
    for (int i = 0; i < TILE_M; i++) begin
      feedA[i] = '0;
      for (int k = 0; k < TILE_K; k++)
        if (int'(ctl.step) == i + k) feedA[i] = aLat[i][k];
    end
    for (int j = 0; j < TILE_N; j++) begin
      feedB[j] = '0;
      for (int k = 0; k < TILE_K; k++)
        if (int'(ctl.step) == j + k) feedB[j] = bLat[k][j];
    end
  end

  // operand seen by each cell: edge feed or the hop register of the neighbour
  always_comb begin
    for (int i = 0; i < TILE_M; i++)
      for (int j = 0; j < TILE_N; j++) begin
        aSeen[i][j] = (j == 0) ? feedA[i] : aHop[i][j-1];
        bSeen[i][j] = (i == 0) ? feedB[j] : bHop[i-1][j];
      end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.capture) begin
      for (int i = 0; i < TILE_M; i++)
        for (int j = 0; j < TILE_N - 1; j++) aHop[i][j] <= '0;
      for (int i = 0; i < TILE_M - 1; i++)
        for (int j = 0; j < TILE_N; j++) bHop[i][j] <= '0;
    end else if (ctl.run) begin
      for (int i = 0; i < TILE_M; i++)
        for (int j = 0; j < TILE_N - 1; j++) aHop[i][j] <= aSeen[i][j];
      for (int i = 0; i < TILE_M - 1; i++)
        for (int j = 0; j < TILE_N; j++) bHop[i][j] <= bSeen[i][j];
    end
  end

  for (genvar gi = 0; gi < TILE_M; gi++) begin : g_row
    for (genvar gj = 0; gj < TILE_N; gj++) begin : g_col
      sa_pe #(.OPW(OPW), .ACCW(ACCW)) u_pe (
        .clk     (clk),
        .rstN    (rstN),
        .load    (ctl.loadOk && preloadEn && (preloadRow == ROWW'(gi))),
        .loadVal (preloadData[gj*ACCW +: ACCW]),
        .run     (ctl.run),
        .aIn     (aSeen[gi][gj]),
        .bIn     (bSeen[gi][gj]),
        .acc     (accAll[gi][gj])
      );
    end
  end

  always_comb begin
    for (int j = 0; j < TILE_N; j++) outData[j*ACCW +: ACCW] = accAll[ctl.rowSel][j];
  end
endmodule

// File: rtl/sa_control.sv
module sa_control
  import sa_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  output ctlStrobes_t     ctl,
  output logic            busy,
  output logic            done,
  output logic            outValid,
  output logic [ROWW-1:0] outRow
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} state_t;

  state_t           state;
  logic [STEPW-1:0] stepCnt;
  logic [ROWW-1:0]  rowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      rowCnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_RUN;
          stepCnt <= '0;
        end
        S_RUN: begin
          if (stepCnt == STEPW'(STEPS - 1)) begin
            state  <= S_DRAIN;
            rowCnt <= '0;
            done   <= 1'b1;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        S_DRAIN: begin
          if (rowCnt == ROWW'(TILE_M - 1)) state <= S_IDLE;
          else rowCnt <= rowCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign outValid = (state == S_DRAIN);
  assign outRow   = rowCnt;

  always_comb begin
    ctl.capture = (state == S_IDLE) && start;
    ctl.run     = (state == S_RUN);
    ctl.loadOk  = (state == S_IDLE);
    ctl.step    = stepCnt;
    ctl.rowSel  = rowCnt;
  end
endmodule

// File: rtl/systolic_mac_tile.sv
module systolic_mac_tile
  import sa_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [TILE_M*TILE_K*OPW-1:0] aTile,
  input  logic [TILE_K*TILE_N*OPW-1:0] bTile,
  input  logic                         preloadEn,
  input  logic [ROWW-1:0]              preloadRow,
  input  logic [TILE_N*ACCW-1:0]       preloadData,
  output logic                         busy,
  output logic                         done,
  output logic                         outValid,
  output logic [ROWW-1:0]              outRow,
  output logic [TILE_N*ACCW-1:0]       outData
);
  ctlStrobes_t ctl;

  sa_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done),
    .outValid (outValid),
    .outRow   (outRow)
  );

  sa_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .aTile       (aTile),
    .bTile       (bTile),
    .preloadEn   (preloadEn),
    .preloadRow  (preloadRow),
    .preloadData (preloadData),
    .outData     (outData)
  );
endmodule

// File: rtl/systolic_mac_tile_chk.sv
module systolic_mac_tile_chk
  import sa_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            outValid,
  input logic [ROWW-1:0] outRow
);
  logic [7:0] since;
  logic       armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      since <= '0;
      armed <= 1'b0;
    end else if (start && !busy) begin
      since <= '0;
      armed <= 1'b1;
    end else begin
      if (since != 8'hFF) since <= since + 1'b1;
      if (done) armed <= 1'b0;
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R3
  done_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (armed && since == 8'(STEPS)));
  // R4
  done_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && since == 8'(STEPS)) |-> done);
  // R5
  first_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (done && outRow == '0));
  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> (outRow == $past(outRow) + 1'b1));
  // R8
  drain_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy);
endmodule

bind systolic_mac_tile systolic_mac_tile_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .outValid (outValid),
  .outRow   (outRow)
);

// File: tb/systolic_mac_tile_tb.sv
`timescale 1ns/1ps
module systolic_mac_tile_tb;
  localparam real CLK_NS = 8.0;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [127:0] aTile = '0;
  logic [127:0] bTile = '0;
  logic         preloadEn = 1'b0;
  logic [1:0]   preloadRow = '0;
  logic [127:0] preloadData = '0;
  logic         busy, done, outValid;
  logic [1:0]   outRow;
  logic [127:0] outData;

  int checks = 0;
  int bad = 0;
  int A [4][4];
  int B [4][4];
  int mAcc [4][4];

  always #(CLK_NS/2) clk = ~clk;

  systolic_mac_tile u_dut (
    .clk(clk), .rstN(rstN), .start(start), .aTile(aTile), .bTile(bTile),
    .preloadEn(preloadEn), .preloadRow(preloadRow), .preloadData(preloadData),
    .busy(busy), .done(done), .outValid(outValid), .outRow(outRow), .outData(outData)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic packTiles();
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++) begin
        aTile[(i*4+k)*8 +: 8] = A[i][k][7:0];
        bTile[(i*4+k)*8 +: 8] = B[i][k][7:0];
      end
  endtask

  function automatic logic [127:0] rowVec(input int r);
    logic [127:0] v;
    for (int j = 0; j < 4; j++) v[j*32 +: 32] = mAcc[r][j];
    return v;
  endfunction

  task automatic preload(input int r, input int v0, input int v1, input int v2, input int v3);
    @(negedge clk);
    preloadEn = 1'b1;
    preloadRow = r[1:0];
    preloadData = {v3, v2, v1, v0};
    @(negedge clk);
    preloadEn = 1'b0;
    mAcc[r][0] = v0; mAcc[r][1] = v1; mAcc[r][2] = v2; mAcc[r][3] = v3;
  endtask

  // strayAt: cycle index during the run at which start and preloadEn are pulsed (0 = none)
  task automatic runTile(input int strayAt);
    packTiles();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R3", {126'd0, busy, done}, {126'd0, 2'b10});
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      start = 1'b0;
      preloadEn = 1'b0;
      if (c < 10) chk(!done && busy, "R3", {126'd0, busy, done}, {126'd0, 2'b10});
      else        chk(done, "R3 R4", {127'd0, done}, 128'd1);
      if (c == strayAt) begin
        start = 1'b1;
        preloadEn = 1'b1;
        preloadRow = 2'd0;
        preloadData = '1;
      end
    end
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++) mAcc[i][j] += A[i][k] * B[k][j];
    for (int r = 0; r < 4; r++) begin
      chk(outValid && outRow == r[1:0], "R5", {125'd0, outValid, outRow}, {125'd0, 1'b1, r[1:0]});
      chk(outData == rowVec(r), "R2 R5 R6 R7", outData, rowVec(r));
      @(negedge clk);
      if (r == 0) chk(!done, "R3", {127'd0, done}, 128'd0);
    end
    chk(!busy && !outValid, "R8", {126'd0, busy, outValid}, 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !outValid, "R1", {125'd0, busy, done, outValid}, 128'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !outValid, "R1", {125'd0, busy, done, outValid}, 128'd0);

    // identity A, random B, preloaded C (R2 R6)
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++) begin
        A[i][k] = (i == k) ? 1 : 0;
        B[i][k] = int'($urandom_range(0, 255)) - 128;
      end
    for (int r = 0; r < 4; r++) preload(r, r*1000 - 1500, -7, 3*r, 100000);
    runTile(0);

    // extreme negatives (R2 sign extension)
    for (int r = 0; r < 4; r++) preload(r, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++) begin A[i][k] = -128; B[i][k] = -128; end
    runTile(0);
    // R7 chained accumulation with mixed extremes, no preload
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++) begin A[i][k] = -128; B[i][k] = 127; end
    runTile(0);

    // R4 R6 stray start and preload during busy
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++) begin
        A[i][k] = i*4 + k - 8;
        B[i][k] = 20 - 3*(i + k);
      end
    runTile(3);
    runTile(9);

    // random sweep
    for (int t = 0; t < 40; t++) begin
      if (t % 2 == 0)
        for (int r = 0; r < 4; r++)
          preload(r, int'($urandom) , -int'($urandom_range(0, 5000)), int'($urandom_range(0, 5000)), 0);
      for (int i = 0; i < 4; i++)
        for (int k = 0; k < 4; k++) begin
          A[i][k] = int'($urandom_range(0, 255)) - 128;
          B[i][k] = int'($urandom_range(0, 255)) - 128;
        end
      runTile((t % 5 == 0) ? 1 + (t % 9) : 0);
    end

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    checks++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule